// File: doc/BRIEF.md
# Dual Double-Buffered Converter Code Register Front End

This block is the digital side of a two-channel, 12-bit voltage-output converter. A host writes codes over an 8-bit parallel bus using active-low strobes. Each channel holds a staging (input) register and an output (DAC) register. The staging register fills in two byte-sized writes. A single transfer strobe then copies both staging registers into both output registers at once, so the two analog outputs change together. The two 12-bit output codes drive the converter cores directly. The analog conversion itself is not part of this block.

Codes are offset binary: the analog output is (D/2048 − 1) times the reference, so the code 0x800 means zero volts. The block can reach that mid-scale code in three ways. A clear sequence writes it permanently into both output registers. A clear held during transparent operation forces it onto the outputs only while the clear is low. A synchronous reset sets it at power-up.

Every strobe, the address, the byte select and the data bus are taken into the system clock domain through a two-flop synchronizer. All actions respond to the synchronized low level of the strobes.

Top module: `dual_dac_frontend`

## Requirements
- R1: `chan_sel` = 0 addresses channel A and `chan_sel` = 1 addresses channel B; a write changes only the addressed channel's staging register.
- R2: With `byte_hi` = 1, a write loads `din[7:0]` into staging bits 11:4 and keeps bits 3:0. With `byte_hi` = 0, a write loads `din[3:0]` into staging bits 3:0 and keeps bits 11:4.
- R3: A staging register changes only while `cs_n` and `wr1_n` are both low. If either is high, a write has no effect, as a later transfer shows.
- R4: While `wr2_n` and `xfer_n` are both low, both output registers take their staging values in the same cycle. Without a transfer, the outputs do not change. A transfer with no new writes leaves the outputs as they were.
- R5: `wr2_n` and `clr_n` both low while `xfer_n` is high loads 0x800 into both output registers. That value remains after the strobes return high.
- R6: With `wr2_n` and `xfer_n` low, `clr_n` low forces both outputs to 0x800. When `clr_n` is released, the outputs return to the staged values. This clear leaves the staging registers unchanged.
- R7: After reset, both outputs and both staging registers hold 0x800, the zero-volt mid-scale code.
- R8: A strobe applied before one clock edge appears at the outputs after the third edge and not after the second. If a load and a transfer fall in the same synchronized cycle, the transfer uses the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Parallel data bus |
| cs_n | input | 1 | Chip select, active low |
| wr1_n | input | 1 | Staging write strobe, active low |
| wr2_n | input | 1 | Output-stage write strobe, active low |
| chan_sel | input | 1 | Channel address (0 = A, 1 = B) |
| byte_hi | input | 1 | 1 = upper byte write, 0 = low nibble write |
| xfer_n | input | 1 | Transfer strobe, active low |
| clr_n | input | 1 | Clear, active low |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |

## Verification
The bench drives writes aimed at one channel and checks that the other channel's outputs stay unchanged after a transfer. A design that decoded the address wrongly would corrupt the neighbour channel. Nibble and byte writes are interleaved so that a register that cleared the other half on a partial write would show a wrong code. The transparent clear is checked both when released and by a later transfer with no new writes; a design that cleared the staging registers would output 0x800 instead of the staged codes. The latched clear is checked to stay in place after release. Outputs are sampled after the second and after the third edge of a transfer, which exposes a synchronizer that is one stage short or one stage long. A load combined with a transfer in the same cycle must show the new data rather than the stale value.

// File: rtl/dac_fe_pkg.sv
// Package: shared constants and helpers for the dual converter front end.
// Assumes two channels and a code wider than the bus.
package dac_fe_pkg;
    localparam int NUM_CH = 2;

    // Mid-scale (zero volts in offset binary) for a given code width.
    function automatic logic [31:0] mid_code(input int w);
        return 32'd1 << (w - 1);
    endfunction
endpackage

// File: rtl/dac_fe_sync.sv
// Module: two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes that multi-bit fields (data, address) are held stable around
// their strobes, so per-bit skew never reaches a qualified action.
module dac_fe_sync #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Two-stage capture into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/dac_fe_input_bank.sv
// Module: per-channel staging registers with byte-split loading.
// Assumes ld is the qualified load (chip select and first write both low).
// in_next exposes the value each register takes this cycle so that a
// same-cycle transfer sees the freshly written data.
module dac_fe_input_bank
    import dac_fe_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld,
    input  logic                           chan,
    input  logic                           byte_hi,
    input  logic [BUS_W-1:0]               din,
    output logic [NUM_CH-1:0][CODE_W-1:0]  in_q,
    output logic [NUM_CH-1:0][CODE_W-1:0]  in_next
);
    localparam int LO_W = CODE_W - BUS_W;
    localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = ld && (chan == 1'(g));

        // Merge the addressed half of the bus into this channel's register.
        always_comb begin
            in_next[g] = in_q[g];
            if (hit) begin
                if (byte_hi) in_next[g][CODE_W-1:LO_W] = din;
                else         in_next[g][LO_W-1:0]      = din[LO_W-1:0];
            end
        end

        // Hold the staging value; mid-scale at reset.
        always_ff @(posedge clk) begin
            if (!rst_n) in_q[g] <= MID;
            else        in_q[g] <= in_next[g];
        end

        // R1: a write to the other channel leaves this one alone.
        p_other_chan_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (ld && chan != 1'(g)) |=> $stable(in_q[g]));
        // R2: an upper-byte write keeps the low nibble.
        p_keep_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && byte_hi) |=> (in_q[g][LO_W-1:0] == $past(in_q[g][LO_W-1:0])));
        // R2: a nibble write keeps the upper byte.
        p_keep_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !byte_hi) |=> (in_q[g][CODE_W-1:LO_W] == $past(in_q[g][CODE_W-1:LO_W])));
    end

    // R3: no qualified load, no staging change.
    p_no_load_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(in_q));
endmodule

// File: rtl/dac_fe_dac_bank.sv
// Module: per-channel output registers with transfer, latched clear and
// transparent forced clear on the output codes.
// Assumes xfer_en and clr_latch are never both high (they differ in xfer).
module dac_fe_dac_bank
    import dac_fe_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          xfer_en,
    input  logic                          clr_latch,
    input  logic                          force_mid,
    input  logic [NUM_CH-1:0][CODE_W-1:0] in_next,
    output logic [NUM_CH-1:0][CODE_W-1:0] code_out
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

    logic [NUM_CH-1:0][CODE_W-1:0] dac_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Output register: mid-scale on reset or latched clear, else transfer.
        always_ff @(posedge clk) begin
            if (!rst_n)         dac_q[g] <= MID;
            else if (clr_latch) dac_q[g] <= MID;
            else if (xfer_en)   dac_q[g] <= in_next[g];
        end

        // Drive the converter: forced mid-scale overrides while asserted.
        always_comb code_out[g] = force_mid ? MID : dac_q[g];

        // R4: a transfer copies the staged (possibly fresh) value.
        p_xfer_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_en |=> (dac_q[g] == $past(in_next[g])));
        // R5: latched clear lands mid-scale in the register.
        p_latch_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
            clr_latch |=> (dac_q[g] == MID));
        // R6: the forced clear shows mid-scale on the output.
        p_force_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
            force_mid |-> (code_out[g] == MID));
    end

    // R4: without transfer or clear the output registers hold.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_en && !clr_latch) |=> $stable(dac_q));
endmodule

// File: rtl/dual_dac_frontend.sv
// Module: top of the dual converter front end. Synchronizes the host bus,
// decodes the strobe levels and connects staging and output banks.
// Assumes a synchronous active-low reset held for at least two clocks.
module dual_dac_frontend
    import dac_fe_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  din,
    input  logic              cs_n,
    input  logic              wr1_n,
    input  logic              wr2_n,
    input  logic              chan_sel,
    input  logic              byte_hi,
    input  logic              xfer_n,
    input  logic              clr_n,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    localparam int STB_W  = 5;
    localparam int SYNC_W = STB_W + 2 + BUS_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{STB_W{1'b1}}, {(SYNC_W-STB_W){1'b0}}};

    logic [SYNC_W-1:0] sync_q;
    logic s_cs_n, s_wr1_n, s_wr2_n, s_xfer_n, s_clr_n, s_chan, s_byte_hi;
    logic [BUS_W-1:0] s_din;
    logic ld, xfer_en, clr_latch, force_mid;
    logic [NUM_CH-1:0][CODE_W-1:0] in_q, in_next, code_out;

    dac_fe_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, wr1_n, wr2_n, xfer_n, clr_n, chan_sel, byte_hi, din}),
        .sync_out (sync_q)
    );

    // Unpack the synchronized bundle.
    assign {s_cs_n, s_wr1_n, s_wr2_n, s_xfer_n, s_clr_n, s_chan, s_byte_hi, s_din} = sync_q;

    // Decode qualified actions from strobe levels.
    always_comb begin
        ld        = !s_cs_n && !s_wr1_n;
        xfer_en   = !s_wr2_n && !s_xfer_n;
        clr_latch = !s_wr2_n && !s_clr_n && s_xfer_n;
        force_mid = xfer_en && !s_clr_n;
    end

    dac_fe_input_bank #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (ld),
        .chan    (s_chan),
        .byte_hi (s_byte_hi),
        .din     (s_din),
        .in_q    (in_q),
        .in_next (in_next)
    );

    dac_fe_dac_bank #(.CODE_W(CODE_W)) u_dac (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_en   (xfer_en),
        .clr_latch (clr_latch),
        .force_mid (force_mid),
        .in_next   (in_next),
        .code_out  (code_out)
    );

    assign code_a = code_out[0];
    assign code_b = code_out[1];

    // R6: the transparent clear never disturbs the staging registers.
    p_force_keeps_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_mid && !ld) |=> $stable(in_q));
endmodule

// File: tb/dual_dac_frontend_tb.sv
module dual_dac_frontend_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din = '0;
    logic        cs_n = 1'b1, wr1_n = 1'b1, wr2_n = 1'b1;
    logic        chan_sel = 1'b0, byte_hi = 1'b0, xfer_n = 1'b1, clr_n = 1'b1;
    logic [11:0] code_a, code_b;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    logic [11:0] exp_in [2];
    logic [11:0] exp_out [2];

    always #10 clk = ~clk;

    dual_dac_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .cs_n(cs_n), .wr1_n(wr1_n),
        .wr2_n(wr2_n), .chan_sel(chan_sel), .byte_hi(byte_hi),
        .xfer_n(xfer_n), .clr_n(clr_n), .code_a(code_a), .code_b(code_b)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        check({req, " chA"}, code_a, exp_out[0]);
        check({req, " chB"}, code_b, exp_out[1]);
    endtask

    task automatic bus_write(input bit ch, input bit hi, input logic [7:0] d);
        din = d; chan_sel = ch; byte_hi = hi; cs_n = 0; wr1_n = 0;
        wait_n(4);
        cs_n = 1; wr1_n = 1;
        wait_n(4);
        if (hi) exp_in[ch][11:4] = d;
        else    exp_in[ch][3:0]  = d[3:0];
    endtask

    task automatic transfer();
        wr2_n = 0; xfer_n = 0;
        wait_n(4);
        wr2_n = 1; xfer_n = 1;
        wait_n(4);
        exp_out[0] = exp_in[0];
        exp_out[1] = exp_in[1];
    endtask

    // R7: reset state.
    task automatic t_reset();
        rst_n = 0; wait_n(4); rst_n = 1; wait_n(4);
        exp_in[0] = 12'h800; exp_in[1] = 12'h800;
        exp_out[0] = 12'h800; exp_out[1] = 12'h800;
        check_outs("R7 reset mid-scale");
        transfer();
        check_outs("R7 staging mid-scale after reset");
    endtask

    // R1/R2: addressing and byte-split loading.
    task automatic t_load();
        bus_write(0, 1, 8'h12);
        bus_write(0, 0, 8'hF3);
        check_outs("R4 no output change before transfer");
        transfer();
        check("R2 chA hi+lo", code_a, 12'h123);
        check("R1 chB untouched", code_b, 12'h800);
        bus_write(1, 0, 8'h0C);
        bus_write(1, 1, 8'hAB);
        transfer();
        check("R1 chB loaded", code_b, 12'hABC);
        check("R1 chA untouched", code_a, 12'h123);
        bus_write(0, 0, 8'h07);
        transfer();
        check("R2 nibble keeps upper byte", code_a, 12'h127);
        bus_write(1, 1, 8'h55);
        transfer();
        check("R2 byte keeps low nibble", code_b, 12'h55C);
        transfer();
        check_outs("R4 transfer without writes unchanged");
    endtask

    // R3: gated writes.
    task automatic t_gate();
        din = 8'hEE; chan_sel = 0; byte_hi = 1; cs_n = 1; wr1_n = 0;
        wait_n(4); wr1_n = 1; wait_n(2);
        cs_n = 0; wr1_n = 1;
        wait_n(4); cs_n = 1; wait_n(4);
        transfer();
        check_outs("R3 cs_n/wr1_n high blocks load");
    endtask

    // R6: transparent forced clear.
    task automatic t_force();
        wr2_n = 0; xfer_n = 0; wait_n(4);
        clr_n = 0; wait_n(4);
        check("R6 chA forced", code_a, 12'h800);
        check("R6 chB forced", code_b, 12'h800);
        clr_n = 1; wait_n(4);
        check_outs("R6 release restores");
        wr2_n = 1; xfer_n = 1; wait_n(4);
        transfer();
        check_outs("R6 staging untouched by forced clear");
    endtask

    // R5: latched clear.
    task automatic t_latch();
        wr2_n = 0; clr_n = 0; wait_n(4);
        wr2_n = 1; clr_n = 1; wait_n(4);
        check("R5 chA latched mid", code_a, 12'h800);
        check("R5 chB latched mid", code_b, 12'h800);
        wait_n(8);
        check("R5 clear persists", code_a, 12'h800);
        transfer();
        check_outs("R5 staging survives latched clear");
    endtask

    // R8: latency and same-cycle load plus transfer.
    task automatic t_timing();
        bus_write(0, 1, 8'h9A);
        wr2_n = 0; xfer_n = 0;
        wait_n(2);
        check("R8 not yet after two edges", code_a, exp_out[0]);
        wait_n(1);
        check("R8 visible after third edge", code_a, exp_in[0]);
        wr2_n = 1; xfer_n = 1; wait_n(4);
        exp_out[0] = exp_in[0];
        din = 8'h3D; chan_sel = 1; byte_hi = 1;
        cs_n = 0; wr1_n = 0; wr2_n = 0; xfer_n = 0;
        wait_n(1);
        cs_n = 1; wr1_n = 1; wr2_n = 1; xfer_n = 1;
        wait_n(5);
        exp_in[1][11:4] = 8'h3D;
        exp_out[1] = exp_in[1];
        check_outs("R8 same-cycle load and transfer uses new data");
    endtask

    initial begin
        t_reset();
        t_load();
        t_gate();
        t_force();
        t_latch();
        t_timing();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule